// File: doc/BRIEF.md
# Serial Port Interrupt Status and Mask Unit

This unit gathers the interrupt conditions of a serial port into one status byte and drives a single interrupt request line. Bit 0 follows transmitter-ready. Bit 1 is the receive condition. A mode input chooses whether bit 1 tracks "receive FIFO full" or "at least one received byte waiting". Bit 2 latches a line break event and holds it until software issues the clear-break miscellaneous command. Bit 7 is reserved for a future change-of-state source and reads as zero, as do bits 6 to 3.

A register port serves one offset, 0x14. A write there loads an 8-bit mask. A read there returns the status byte. The interrupt request is a registered OR of the bitwise AND of status and mask. Status bits 0 and 1 are resampled from the flag inputs on every clock edge, so they follow every register write and every FIFO change. The flags are produced elsewhere in the port.

The break bit is held by a two-state machine:
- BRK_IDLE: no break is pending.
- BRK_PEND: a break event has been seen and has not yet been cleared.

It has two transitions:
- BRK_IDLE to BRK_PEND, taken on `brk_event`.
- BRK_PEND to BRK_IDLE, taken on a valid clear command (miscellaneous code 5) in a cycle with no new break event.

Top module: `uirq_top`

## Requirements
- R1: After reset the status byte reads 0x00 and `irq` is low. The mask is 0x00, so `irq` stays low whatever the flags do until the mask is written.
- R2: Status bit 0 equals the value of `tx_ready` at the previous rising clock edge.
- R3: With `rx_src_full` low, status bit 1 equals the previous-edge value of `rx_ready`, and `rx_full` has no effect on it.
- R4: With `rx_src_full` high, status bit 1 equals the previous-edge value of `rx_full`, and `rx_ready` has no effect on it.
- R5: A cycle with `brk_event` high sets status bit 2 at the next edge. The bit then stays set for any number of cycles without a clear command.
- R6: Status bit 2 is cleared only when `cmd_valid` is high and `cmd_misc` equals 5 (3'b101) in a cycle with `brk_event` low. Other codes, or code 5 with `cmd_valid` low, leave it set. A break event in the same cycle as the clear keeps the bit set.
- R7: Status bits 7 to 3 always read as zero.
- R8: A write (`bus_wr` high) with `bus_addr` equal to 0x14 loads `bus_wdata` into the mask at the next edge. Writes at any other offset leave the mask unchanged.
- R9: `irq` is high exactly when the status byte and the mask, as held in the previous cycle, have at least one common set bit. A mask change shows on `irq` one cycle after it is loaded. A flag change shows two cycles after the flag moves.
- R10: `bus_rdata` returns the status byte when `bus_rd` is high and `bus_addr` is 0x14, and returns 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; status at offset 0x14, otherwise zero |
| tx_ready | input | 1 | Transmitter can accept a byte |
| rx_ready | input | 1 | At least one received byte is waiting |
| rx_full | input | 1 | Receive FIFO is full |
| rx_src_full | input | 1 | Mode bit: receive interrupt follows FIFO full when high |
| brk_event | input | 1 | One-cycle pulse on a detected line break |
| cmd_valid | input | 1 | Command strobe |
| cmd_misc | input | 3 | Miscellaneous command field; 5 clears the break bit |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that the flag inputs and the mode input are synchronous to `clk` and are sampled only at its rising edge. They also assume that `cmd_misc` is meaningful only while `cmd_valid` is high. The stimulus follows these assumptions by changing every input on the falling edge and holding it through the next rising edge. Break pulses and commands are single-cycle strobes, except that break events and clears are deliberately made to coincide once to exercise the set-wins rule.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    localparam int STAT_W  = 8;
    localparam int BIT_TX  = 0;
    localparam int BIT_RX  = 1;
    localparam int BIT_BRK = 2;
    localparam int BIT_COS = 7;

    typedef enum logic [0:0] {
        BRK_IDLE = 1'b0,
        BRK_PEND = 1'b1
    } brk_state_t;
endpackage

// File: rtl/uirq_flag_sample.sv
module uirq_flag_sample (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_ready,
    input  logic rx_ready,
    input  logic rx_full,
    input  logic rx_src_full,
    output logic tx_bit,
    output logic rx_bit
);
    logic rx_src;

    always_comb begin
        rx_src = rx_src_full ? rx_full : rx_ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_bit <= 1'b0;
            rx_bit <= 1'b0;
        end else begin
            tx_bit <= tx_ready;
            rx_bit <= rx_src;
        end
    end

    AST_TX_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> tx_bit == $past(tx_ready)); // R2
    AST_RX_READY_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_src_full |=> rx_bit == $past(rx_ready)); // R3
    AST_RX_FULL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        rx_src_full |=> rx_bit == $past(rx_full)); // R4
endmodule

// File: rtl/uirq_brk_fsm.sv
module uirq_brk_fsm
    import uirq_pkg::*;
#(
    parameter int          CMD_W    = 3,
    parameter logic [CMD_W-1:0] CLR_CODE = 3'd5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             brk_event,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_misc,
    output logic             brk_bit
);
    brk_state_t state_q, state_d;
    logic       clr_req;

    always_comb begin
        clr_req = cmd_valid && (cmd_misc == CLR_CODE);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BRK_IDLE: if (brk_event) state_d = BRK_PEND;
            BRK_PEND: if (clr_req && !brk_event) state_d = BRK_IDLE;
            default:  state_d = BRK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BRK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        brk_bit = (state_q == BRK_PEND);
    end

    AST_BRK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        brk_event |=> brk_bit); // R5
    AST_BRK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_bit && !clr_req) |=> brk_bit); // R5
    AST_BRK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !brk_event) |=> !brk_bit); // R6
endmodule

// File: rtl/uirq_mask_irq.sv
module uirq_mask_irq #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we,
    input  logic [DATA_W-1:0] mask_wdata,
    input  logic [DATA_W-1:0] status,
    output logic              irq
);
    logic [DATA_W-1:0] mask_q;
    logic              hit;

    always_comb begin
        hit = |(status & mask_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            irq    <= 1'b0;
        end else begin
            if (mask_we) mask_q <= mask_wdata;
            irq <= hit;
        end
    end

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> mask_q == $past(mask_wdata)); // R8
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask_q)); // R8
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> !irq); // R1
endmodule

// File: rtl/uirq_top.sv
module uirq_top
    import uirq_pkg::*;
#(
    parameter int             ADDR_W   = 6,
    parameter int             CMD_W    = 3,
    parameter logic [ADDR_W-1:0] STAT_OFS = 6'h14,
    parameter logic [CMD_W-1:0]  CLR_CODE = 3'd5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [STAT_W-1:0] bus_wdata,
    output logic [STAT_W-1:0] bus_rdata,
    input  logic              tx_ready,
    input  logic              rx_ready,
    input  logic              rx_full,
    input  logic              rx_src_full,
    input  logic              brk_event,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_misc,
    output logic              irq
);
    logic              tx_bit, rx_bit, brk_bit;
    logic              hit_ofs;
    logic [STAT_W-1:0] status;

    uirq_flag_sample u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_ready    (tx_ready),
        .rx_ready    (rx_ready),
        .rx_full     (rx_full),
        .rx_src_full (rx_src_full),
        .tx_bit      (tx_bit),
        .rx_bit      (rx_bit)
    );

    uirq_brk_fsm #(
        .CMD_W    (CMD_W),
        .CLR_CODE (CLR_CODE)
    ) u_brk (
        .clk       (clk),
        .rst_n     (rst_n),
        .brk_event (brk_event),
        .cmd_valid (cmd_valid),
        .cmd_misc  (cmd_misc),
        .brk_bit   (brk_bit)
    );

    always_comb begin
        status          = '0;
        status[BIT_TX]  = tx_bit;
        status[BIT_RX]  = rx_bit;
        status[BIT_BRK] = brk_bit;
        status[BIT_COS] = 1'b0;
        hit_ofs         = (bus_addr == STAT_OFS);
    end

    uirq_mask_irq #(
        .DATA_W (STAT_W)
    ) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_we    (bus_wr && hit_ofs),
        .mask_wdata (bus_wdata),
        .status     (status),
        .irq        (irq)
    );

    always_comb begin
        bus_rdata = (bus_rd && hit_ofs) ? status : '0;
    end

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(tx_bit || rx_bit || brk_bit)); // R9
endmodule

// File: tb/uirq_top_tb_top.sv
module uirq_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus_addr = 6'h0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h0;
    logic [7:0] bus_rdata;
    logic       tx_ready = 1'b0, rx_ready = 1'b0, rx_full = 1'b0, rx_src_full = 1'b0;
    logic       brk_event = 1'b0, cmd_valid = 1'b0;
    logic [2:0] cmd_misc = 3'd0;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    uirq_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_ready(tx_ready), .rx_ready(rx_ready), .rx_full(rx_full),
        .rx_src_full(rx_src_full), .brk_event(brk_event),
        .cmd_valid(cmd_valid), .cmd_misc(cmd_misc), .irq(irq)
    );

    // fields: req id, {tx, rx, full, mode}, mask, expected status, expected irq
    localparam logic [24:0] VEC [10] = '{
        {4'd2,  4'b1000, 8'hFF, 8'h01, 1'b1},  // R2
        {4'd3,  4'b0100, 8'h02, 8'h02, 1'b1},  // R3
        {4'd4,  4'b0101, 8'h02, 8'h00, 1'b0},  // R4 ready ignored
        {4'd4,  4'b0111, 8'h02, 8'h02, 1'b1},  // R4
        {4'd3,  4'b0010, 8'h02, 8'h00, 1'b0},  // R3 full ignored
        {4'd9,  4'b1110, 8'h04, 8'h03, 1'b0},  // R9 no common bit
        {4'd9,  4'b1000, 8'h00, 8'h01, 1'b0},  // R9
        {4'd9,  4'b0000, 8'hFF, 8'h00, 1'b0},  // R9
        {4'd9,  4'b1101, 8'h01, 8'h01, 1'b1},  // R9
        {4'd10, 4'b0110, 8'hFE, 8'h02, 1'b1}   // R10
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 6'h14; bus_rd = 1'b1;
    endtask

    task automatic cmd(input logic v, input logic [2:0] c, input logic brk);
        @(negedge clk);
        cmd_valid = v; cmd_misc = c; brk_event = brk;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_misc = 3'd0; brk_event = 1'b0;
    endtask

    initial begin
        #(8 * 5000);
        n_bad++;
        $display("FAIL watchdog actual=%02h expected=%02h", 8'h0, 8'h1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        bus_rd = 1'b1; bus_addr = 6'h14;
        repeat (3) @(negedge clk);
        chk("R1 status in reset", bus_rdata, 8'h00);
        chk("R1 irq in reset", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            {tx_ready, rx_ready, rx_full, rx_src_full} = VEC[i][20:17];
            bus_addr = 6'h14; bus_wdata = VEC[i][16:9]; bus_wr = 1'b1; bus_rd = 1'b0;
            @(negedge clk);
            bus_wr = 1'b0; bus_rd = 1'b1;
            @(negedge clk);
            chk($sformatf("R%0d status vec %0d", VEC[i][24:21], i), bus_rdata, VEC[i][8:1]);
            chk($sformatf("R%0d irq vec %0d", VEC[i][24:21], i), {7'd0, irq}, {7'd0, VEC[i][0]});
        end

        // R5: break event sets bit 2 and it sticks
        cmd(1'b0, 3'd0, 1'b1);
        chk("R5 break set", bus_rdata, 8'h06);
        repeat (3) @(negedge clk);
        chk("R5 break sticky", bus_rdata, 8'h06);

        // R6: only valid code 5 clears, set wins on collision
        cmd(1'b1, 3'd4, 1'b0);
        chk("R6 other code keeps", bus_rdata, 8'h06);
        cmd(1'b0, 3'd5, 1'b0);
        chk("R6 invalid strobe keeps", bus_rdata, 8'h06);
        cmd(1'b1, 3'd5, 1'b0);
        chk("R6 clear", bus_rdata, 8'h02);
        cmd(1'b1, 3'd5, 1'b1);
        chk("R6 event wins over clear", bus_rdata, 8'h06);

        // R7: all sources set, upper bits stay zero
        @(negedge clk);
        tx_ready = 1'b1; rx_ready = 1'b1; rx_full = 1'b1; rx_src_full = 1'b0;
        @(negedge clk);
        chk("R7 full status", bus_rdata, 8'h07);
        chk("R7 upper bits zero", bus_rdata & 8'hF8, 8'h00);

        // R9: mask is FE, irq high; clear mask and watch the one-cycle latency
        @(negedge clk);
        chk("R9 irq before mask clear", {7'd0, irq}, 8'h01);
        write(6'h14, 8'h00);
        chk("R9 irq still old one cycle after load", {7'd0, irq}, 8'h01);
        @(negedge clk);
        chk("R9 irq follows cleared mask", {7'd0, irq}, 8'h00);

        // R8: write at another offset leaves the mask at zero
        write(6'h10, 8'hFF);
        repeat (2) @(negedge clk);
        chk("R8 foreign offset ignored", {7'd0, irq}, 8'h00);
        write(6'h14, 8'h04);
        @(negedge clk);
        chk("R8 mask load", {7'd0, irq}, 8'h01);

        // R10: read decode
        bus_addr = 6'h10; bus_rd = 1'b1;
        #1 chk("R10 other offset reads zero", bus_rdata, 8'h00);
        bus_addr = 6'h14; bus_rd = 1'b0;
        #1 chk("R10 no strobe reads zero", bus_rdata, 8'h00);
        bus_rd = 1'b1;
        #1 chk("R10 status read", bus_rdata, 8'h07);

        // R1: mid-run reset clears status, break and mask
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 status after reset", bus_rdata, 8'h00);
        chk("R1 irq after reset", {7'd0, irq}, 8'h00);
        rst_n = 1'b1; rx_ready = 1'b0; rx_full = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 break cleared by reset", bus_rdata, 8'h01);
        chk("R1 mask cleared by reset", {7'd0, irq}, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule